// File: doc/BRIEF.md
# PROM Programming Sequencer

This block is the host-side controller that burns a run of bytes into a one-time programmable memory. The memory is driven through four mode-select lines, a programming clock, a byte-wide data path and two supply-select outputs. On a start pulse the sequencer waits for the supplies to settle at their nominal level. It then clears the device address, switches both supplies to programming level and parks the device in inhibit.

Each byte is fetched from a byte source. The sequencer writes the byte with a fixed-length pulse, inhibits, and reads it back in verify mode. It repeats this write, inhibit and verify loop until the read-back matches. The byte is then reinforced with one extra write whose length is the base pulse times the number of attempts. Four clock pulses step the device to the next address.

After the last byte, or after a byte that never verifies within the attempt limit, the sequencer clears the address, drops the supplies to nominal and pulses done. A failure leaves a flag and the failing address for the host to read.

Top module: `prom_prog_seq`

## Requirements
- R1: While reset is asserted, and after its release until a start, the outputs are idle: mode_pins = 4'b0000, both supply selects low, prog_clk low, dq_oe low, byte_req low, done low and fail low.
- R2: A start accepted on a clock edge is followed by WAIT_CYC idle cycles with prog_clk low and supplies nominal. Clear mode (mode_pins = 4'b0101) then appears, both supply selects rise together one cycle later while clear is still held, and inhibit (4'b1101) follows one cycle after that, before any write.
- R3: Every write of a byte other than the final extra write lasts PULSE_CYC cycles in write mode (4'b1110) with dq_oe high and dq_out equal to the byte. It is followed by inhibit and then verify (4'b1100).
- R4: If the byte read in verify differs from the byte written, the write, inhibit and verify steps repeat. The number of write pulses before the extra write equals the number of attempts needed.
- R5: After a matching verify, one extra write is applied lasting PULSE_CYC times the number of attempts for that byte.
- R6: After the extra write, inhibit is held while exactly four prog_clk pulses are issued, each high for CLK_HALF cycles. Bytes are requested through byte_req/byte_addr in address order starting at 0.
- R7: After the last byte, clear mode is issued with supplies still at programming level, then the supplies return to nominal, then done is high for exactly one cycle with mode_pins idle.
- R8: If the verify of attempt MAX_TRIES still mismatches, no extra write is made. fail rises, fail_addr holds that byte's address, the finish sequence of R7 runs, and fail holds until the next accepted start clears it.
- R9: dq_oe is high only in write mode, and is low in the cycle before verify mode is entered.
- R10: The read-back is sampled at the end of the SETTLE_CYC-th cycle in verify mode. Data that becomes correct only in that cycle still counts as a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to program the whole block |
| done | output | 1 | One-cycle pulse when the run has finished |
| byte_req | output | 1 | Request for the byte at byte_addr |
| byte_addr | output | AW | Address of the requested byte |
| byte_vld | input | 1 | Byte source answers with byte_data |
| byte_data | input | DW | Byte to program |
| mode_pins | output | 4 | Mode select lines, bit 0 first |
| prog_clk | output | 1 | Address-advance clock to the device |
| vdd_prog | output | 1 | Logic supply at programming level |
| vpp_prog | output | 1 | Programming supply at programming level |
| dq_out | output | DW | Data driven to the device |
| dq_oe | output | 1 | Enable for dq_out on the shared bus |
| dq_in | input | DW | Data read from the device |
| fail | output | 1 | Programming stopped on a byte that would not verify |
| fail_addr | output | AW | Address of the failing byte |

## Verification
Two functions meet in a single cycle: the verify compare and the attempt limit. On attempt MAX_TRIES, the same sample decides whether the extra write starts or the run is abandoned. The device model needs exactly MAX_TRIES attempts on one byte and MAX_TRIES+1 on another. It also makes its read-back correct only in the last settle cycle, so the bench can tell an early or late sample from a good one. Each case is judged at the ports from write-pulse counts, the extra-write length, the clock-pulse count, fail and fail_addr.

// File: rtl/prom_seq_pkg.sv
package prom_seq_pkg;

  // mode line codes, bit 0 is the first mode line
  localparam logic [3:0] MODE_IDLE    = 4'b0000;
  localparam logic [3:0] MODE_CLEAR   = 4'b0101;
  localparam logic [3:0] MODE_WRITE   = 4'b1110;
  localparam logic [3:0] MODE_VERIFY  = 4'b1100;
  localparam logic [3:0] MODE_INHIBIT = 4'b1101;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAIT,
    ST_CLR,
    ST_SUP,
    ST_INH0,
    ST_FETCH,
    ST_WR,
    ST_INH1,
    ST_VFY,
    ST_XWR,
    ST_INH2,
    ST_ADV,
    ST_FCLR,
    ST_FSUP,
    ST_DONE
  } seq_state_t;

endpackage

// File: rtl/psq_timer.sv
module psq_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign zero   = (cnt_q == '0);
  assign cnt_en = ld | ~zero;

  always_comb begin
    cnt_d = cnt_q;
    if (ld)         cnt_d = ld_val;
    else if (!zero) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/psq_clk_burst.sv
module psq_clk_burst #(
  parameter int NPULSE = 4,
  parameter int HALF   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic clk_o,
  output logic last
);

  localparam int NPH = 2 * NPULSE;
  localparam int PW  = (NPH > 1) ? $clog2(NPH) : 1;
  localparam int HW  = (HALF > 1) ? $clog2(HALF) : 1;

  logic          act_q, act_d;
  logic [PW-1:0] ph_q, ph_d;
  logic [HW-1:0] hc_q, hc_d;
  logic          hc_end, ph_end, upd_en;

  assign hc_end = (hc_q == '0);
  assign ph_end = (ph_q == PW'(NPH - 1));
  assign last   = act_q & hc_end & ph_end;
  assign clk_o  = act_q & ~ph_q[0];
  assign upd_en = go | act_q;

  always_comb begin
    act_d = act_q;
    ph_d  = ph_q;
    hc_d  = hc_q;
    if (go) begin
      act_d = 1'b1;
      ph_d  = '0;
      hc_d  = HW'(HALF - 1);
    end else if (act_q) begin
      if (hc_end) begin
        hc_d = HW'(HALF - 1);
        if (ph_end) act_d = 1'b0;
        else        ph_d  = ph_q + PW'(1);
      end else begin
        hc_d = hc_q - HW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ph_q  <= '0;
      hc_q  <= '0;
    end else if (upd_en) begin
      act_q <= act_d;
      ph_q  <= ph_d;
      hc_q  <= hc_d;
    end
  end

endmodule

// File: rtl/prom_prog_seq.sv
module prom_prog_seq
  import prom_seq_pkg::*;
#(
  parameter int DW         = 8,
  parameter int NUM_BYTES  = 256,
  parameter int WAIT_CYC   = 1250,
  parameter int PULSE_CYC  = 125000,
  parameter int SETTLE_CYC = 4,
  parameter int MAX_TRIES  = 25,
  parameter int CLK_HALF   = 4,
  localparam int AW = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          done,
  output logic          byte_req,
  output logic [AW-1:0] byte_addr,
  input  logic          byte_vld,
  input  logic [DW-1:0] byte_data,
  output logic [3:0]    mode_pins,
  output logic          prog_clk,
  output logic          vdd_prog,
  output logic          vpp_prog,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  input  logic [DW-1:0] dq_in,
  output logic          fail,
  output logic [AW-1:0] fail_addr
);

  localparam int TW     = $clog2(MAX_TRIES + 1);
  localparam int CW     = $clog2(MAX_TRIES * PULSE_CYC + WAIT_CYC + SETTLE_CYC + 1);
  localparam int NPULSE = 4;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  seq_state_t    st_q, st_d;
  logic [AW-1:0] addr_q;
  logic [TW-1:0] tries_q;
  logic [DW-1:0] byte_q;
  logic          fail_q;
  logic [AW-1:0] faddr_q;

  logic          tmr_ld, tmr_zero;
  logic [CW-1:0] tmr_val;
  logic          burst_go, burst_last;

  logic addr_clr, addr_inc, tries_one, tries_inc, byte_ld, fail_set, fail_clr;
  logic addr_last, at_max, match;

  assign addr_last = (addr_q == AW'(NUM_BYTES - 1));
  assign at_max    = (tries_q == TW'(MAX_TRIES));
  assign match     = (dq_in == byte_q);

  psq_timer #(.CW(CW)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .ld     (tmr_ld),
    .ld_val (tmr_val),
    .zero   (tmr_zero)
  );

  psq_clk_burst #(.NPULSE(NPULSE), .HALF(CLK_HALF)) u_burst (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .go    (burst_go),
    .clk_o (prog_clk),
    .last  (burst_last)
  );

  // next-state logic
  always_comb begin
    st_d      = st_q;
    tmr_ld    = 1'b0;
    tmr_val   = '0;
    burst_go  = 1'b0;
    addr_clr  = 1'b0;
    addr_inc  = 1'b0;
    tries_one = 1'b0;
    tries_inc = 1'b0;
    byte_ld   = 1'b0;
    fail_set  = 1'b0;
    fail_clr  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_d     = ST_WAIT;
        tmr_ld   = 1'b1;
        tmr_val  = CW'(WAIT_CYC - 1);
        fail_clr = 1'b1;
      end
      ST_WAIT: if (tmr_zero) st_d = ST_CLR;
      ST_CLR: begin
        st_d     = ST_SUP;
        addr_clr = 1'b1;
      end
      ST_SUP:  st_d = ST_INH0;
      ST_INH0: st_d = ST_FETCH;
      ST_FETCH: if (byte_vld) begin
        st_d      = ST_WR;
        byte_ld   = 1'b1;
        tries_one = 1'b1;
        tmr_ld    = 1'b1;
        tmr_val   = CW'(PULSE_CYC - 1);
      end
      ST_WR: if (tmr_zero) st_d = ST_INH1;
      ST_INH1: begin
        st_d    = ST_VFY;
        tmr_ld  = 1'b1;
        tmr_val = CW'(SETTLE_CYC - 1);
      end
      ST_VFY: if (tmr_zero) begin
        if (match) begin
          st_d    = ST_XWR;
          tmr_ld  = 1'b1;
          tmr_val = CW'(tries_q) * CW'(PULSE_CYC) - CW'(1);
        end else if (at_max) begin
          st_d     = ST_FCLR;
          fail_set = 1'b1;
        end else begin
          st_d      = ST_WR;
          tries_inc = 1'b1;
          tmr_ld    = 1'b1;
          tmr_val   = CW'(PULSE_CYC - 1);
        end
      end
      ST_XWR: if (tmr_zero) st_d = ST_INH2;
      ST_INH2: begin
        st_d     = ST_ADV;
        burst_go = 1'b1;
      end
      ST_ADV: if (burst_last) begin
        if (addr_last) st_d = ST_FCLR;
        else begin
          st_d     = ST_FETCH;
          addr_inc = 1'b1;
        end
      end
      ST_FCLR: st_d = ST_FSUP;
      ST_FSUP: st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // state and datapath registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) st_q <= ST_IDLE;
    else             st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   addr_q <= '0;
    else if (addr_clr) addr_q <= '0;
    else if (addr_inc) addr_q <= addr_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)    tries_q <= '0;
    else if (tries_one) tries_q <= TW'(1);
    else if (tries_inc) tries_q <= tries_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  byte_q <= '0;
    else if (byte_ld) byte_q <= byte_data;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      fail_q  <= 1'b0;
      faddr_q <= '0;
    end else if (fail_set) begin
      fail_q  <= 1'b1;
      faddr_q <= addr_q;
    end else if (fail_clr) begin
      fail_q  <= 1'b0;
      faddr_q <= '0;
    end
  end

  // output decode from the state register
  always_comb begin
    unique case (st_q)
      ST_CLR, ST_SUP, ST_FCLR, ST_FSUP:          mode_pins = MODE_CLEAR;
      ST_INH0, ST_FETCH, ST_INH1, ST_INH2, ST_ADV: mode_pins = MODE_INHIBIT;
      ST_WR, ST_XWR:                             mode_pins = MODE_WRITE;
      ST_VFY:                                    mode_pins = MODE_VERIFY;
      default:                                   mode_pins = MODE_IDLE;
    endcase
  end

  always_comb begin
    unique case (st_q)
      ST_SUP, ST_INH0, ST_FETCH, ST_WR, ST_INH1,
      ST_VFY, ST_XWR, ST_INH2, ST_ADV, ST_FCLR: vdd_prog = 1'b1;
      default:                                 vdd_prog = 1'b0;
    endcase
  end

  assign vpp_prog  = vdd_prog;
  assign dq_oe     = (st_q == ST_WR) | (st_q == ST_XWR);
  assign dq_out    = byte_q;
  assign byte_req  = (st_q == ST_FETCH);
  assign byte_addr = addr_q;
  assign done      = (st_q == ST_DONE);
  assign fail      = fail_q;
  assign fail_addr = faddr_q;

endmodule

// File: rtl/psq_checker.sv
module psq_checker
  import prom_seq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       done,
  input logic [3:0] mode_pins,
  input logic       prog_clk,
  input logic       vdd_prog,
  input logic       vpp_prog,
  input logic       dq_oe,
  input logic       fail
);

  AST_OE_ONLY_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> mode_pins == MODE_WRITE); // R9

  AST_OE_LOW_BEFORE_VERIFY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_pins == MODE_VERIFY) |-> !$past(dq_oe)); // R9

  AST_VERIFY_AFTER_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_pins == MODE_VERIFY && $past(mode_pins) != MODE_VERIFY) |-> $past(mode_pins) == MODE_INHIBIT); // R3

  AST_WRITE_AT_PROG_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_pins == MODE_WRITE) |-> (vpp_prog && vdd_prog)); // R3

  AST_SUPPLIES_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    vdd_prog == vpp_prog); // R2

  AST_SUPPLY_RISE_IN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vdd_prog) |-> mode_pins == MODE_CLEAR); // R2

  AST_CLK_ONLY_IN_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    prog_clk |-> mode_pins == MODE_INHIBIT); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_DONE_AT_NOMINAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!vdd_prog && mode_pins == MODE_IDLE)); // R7

  AST_FAIL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> fail); // R8

endmodule

bind prom_prog_seq psq_checker u_psq_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .done      (done),
  .mode_pins (mode_pins),
  .prog_clk  (prog_clk),
  .vdd_prog  (vdd_prog),
  .vpp_prog  (vpp_prog),
  .dq_oe     (dq_oe),
  .fail      (fail)
);

// File: tb/tb_prom_prog_seq.sv
`timescale 1ns/1ps
module tb_prom_prog_seq;
  import prom_seq_pkg::*;

  localparam int NB     = 4;
  localparam int AW     = 2;
  localparam int PULSE  = 16;
  localparam int WAITC  = 10;
  localparam int SETTLE = 3;
  localparam int MAXT   = 25;
  localparam int HALF   = 2;
  localparam int NROWS  = 6;

  // row: base byte [27:20], attempts needed for address a at [19-5a -: 5]
  localparam logic [27:0] VEC [NROWS] = '{
    {8'hA5, 5'd1,  5'd1,  5'd1, 5'd1 },
    {8'h3C, 5'd2,  5'd5,  5'd1, 5'd3 },
    {8'h00, 5'd25, 5'd1,  5'd4, 5'd2 },
    {8'hF0, 5'd1,  5'd26, 5'd1, 5'd1 },
    {8'h81, 5'd3,  5'd2,  5'd1, 5'd26},
    {8'h5A, 5'd1,  5'd2,  5'd2, 5'd1 }
  };

  logic clk = 1'b0;
  logic rst_n, start, byte_vld;
  logic [7:0] byte_data, dq_in, dq_out;
  logic done, byte_req, prog_clk, vdd_prog, vpp_prog, dq_oe, fail;
  logic [AW-1:0] byte_addr, fail_addr;
  logic [3:0] mode_pins;

  always #4 clk = ~clk;

  prom_prog_seq #(
    .DW(8), .NUM_BYTES(NB), .WAIT_CYC(WAITC), .PULSE_CYC(PULSE),
    .SETTLE_CYC(SETTLE), .MAX_TRIES(MAXT), .CLK_HALF(HALF)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .byte_req(byte_req), .byte_addr(byte_addr), .byte_vld(byte_vld),
    .byte_data(byte_data), .mode_pins(mode_pins), .prog_clk(prog_clk),
    .vdd_prog(vdd_prog), .vpp_prog(vpp_prog), .dq_out(dq_out),
    .dq_oe(dq_oe), .dq_in(dq_in), .fail(fail), .fail_addr(fail_addr)
  );

  int errs = 0, checks = 0;
  int cyc = 0;
  logic [7:0] cur_base;
  int need_m [NB+1];
  int pulses [NB+1];
  int last_len [NB+1];
  logic [7:0] mem [NB+1];
  int t_start, t_clr, t_sup, t_inh, t_wr;
  int wrun, vrun, hrun, dev_addr, ccnt, rises;
  int bad_wlen, bad_wdat, bad_hw, bad_order;
  bit done_seen, done_sup;
  logic [3:0] pmode, lastnz, done_prev;
  logic pclk;

  function automatic logic [7:0] dat(input int a);
    return cur_base + 8'(a * 8'h11);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // device model and byte source, sampled away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      pmode = MODE_IDLE; pclk = 1'b0; wrun = 0; vrun = 0; hrun = 0;
      dev_addr = 0; ccnt = 0; byte_vld = 1'b0; byte_data = 8'h00; dq_in = 8'h00;
    end else begin
      if (start && t_start < 0) t_start = cyc;
      if (mode_pins == MODE_CLEAR && t_clr < 0) t_clr = cyc;
      if (vdd_prog && t_sup < 0) t_sup = cyc;
      if (mode_pins == MODE_INHIBIT && t_inh < 0) t_inh = cyc;
      if (mode_pins == MODE_WRITE && t_wr < 0) t_wr = cyc;
      if (mode_pins == MODE_WRITE) begin
        if (pmode != MODE_WRITE) begin
          if (pulses[dev_addr] > 0 && last_len[dev_addr] != PULSE) bad_wlen++;
          pulses[dev_addr]++;
          wrun = 0;
        end
        wrun++;
        last_len[dev_addr] = wrun;
        if (dq_oe) mem[dev_addr] = dq_out;
        if (!dq_oe || dq_out != dat(dev_addr)) bad_wdat++;
      end
      if (mode_pins == MODE_VERIFY) begin
        vrun = (pmode == MODE_VERIFY) ? vrun + 1 : 1;
        dq_in = (vrun >= SETTLE && pulses[dev_addr] >= need_m[dev_addr]) ?
                mem[dev_addr] : ~mem[dev_addr];
      end else begin
        dq_in = 8'h00;
      end
      if (prog_clk && !pclk) begin
        rises++; ccnt++; hrun = 1;
        if (ccnt == 4) begin ccnt = 0; dev_addr++; end
      end else if (prog_clk) begin
        hrun++;
      end
      if (!prog_clk && pclk && hrun != HALF) bad_hw++;
      if (mode_pins == MODE_CLEAR) begin dev_addr = 0; ccnt = 0; end
      byte_vld = byte_req;
      if (byte_req) begin
        byte_data = dat(int'(byte_addr));
        if (int'(byte_addr) != dev_addr) bad_order++;
      end
      if (mode_pins != MODE_IDLE) lastnz = mode_pins;
      if (done) begin
        done_seen = 1'b1;
        done_sup  = vdd_prog | vpp_prog;
        done_prev = lastnz;
      end
      pmode = mode_pins;
      pclk  = prog_clk;
    end
  end

  task automatic finish_now();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  task automatic check_idle(input string tag);
    chk(mode_pins == MODE_IDLE, tag, int'(mode_pins), int'(MODE_IDLE));
    chk(!vdd_prog && !vpp_prog, tag, int'(vdd_prog), 0);
    chk(!prog_clk && !dq_oe && !byte_req, tag, int'({prog_clk, dq_oe, byte_req}), 0);
    chk(!done && !fail, tag, int'({done, fail}), 0);
  endtask

  task automatic run_row(input int r);
    int fa, done_cnt, ebytes, expp;
    cur_base = VEC[r][27:20];
    for (int a = 0; a <= NB; a++) begin
      need_m[a] = (a < NB) ? int'(VEC[r][19 - 5*a -: 5]) : 0;
      pulses[a] = 0; last_len[a] = 0; mem[a] = 8'h00;
    end
    t_start = -1; t_clr = -1; t_sup = -1; t_inh = -1; t_wr = -1;
    rises = 0; bad_wlen = 0; bad_wdat = 0; bad_hw = 0; bad_order = 0;
    done_seen = 1'b0; done_sup = 1'b0; lastnz = MODE_IDLE; done_prev = MODE_IDLE;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    done_cnt = 0;
    while (!done_seen) begin
      @(posedge clk);
      done_cnt++;
      if (done_cnt > 40000) begin
        chk(1'b0, "watchdog R7", done_cnt, 40000);
        finish_now();
      end
    end
    fa = -1;
    for (int a = 0; a < NB; a++) if (need_m[a] > MAXT && fa < 0) fa = a;
    #1;
    chk(fail == (fa >= 0), "R8 fail flag", int'(fail), int'(fa >= 0));
    if (fa >= 0) chk(int'(fail_addr) == fa, "R8 fail_addr", int'(fail_addr), fa);
    for (int a = 0; a < NB; a++) begin
      if (fa < 0 || a < fa) begin
        expp = need_m[a] + 1;
        chk(last_len[a] == need_m[a] * PULSE, "R5 extra write length", last_len[a], need_m[a] * PULSE);
        chk(mem[a] == dat(a), "R4 programmed byte", int'(mem[a]), int'(dat(a)));
      end else if (a == fa) begin
        expp = MAXT;
      end else begin
        expp = 0;
      end
      chk(pulses[a] == expp, "R4 R10 write pulses", pulses[a], expp);
    end
    ebytes = (fa < 0) ? NB : fa;
    chk(rises == 4 * ebytes, "R6 clock pulses", rises, 4 * ebytes);
    chk(bad_hw == 0, "R6 clock high width", bad_hw, 0);
    chk(bad_order == 0, "R6 byte order", bad_order, 0);
    chk(t_clr == t_start + WAITC + 1, "R2 wait then clear", t_clr - t_start, WAITC + 1);
    chk(t_sup == t_clr + 1, "R2 supplies after clear", t_sup - t_clr, 1);
    chk(t_inh == t_clr + 2, "R2 inhibit after supplies", t_inh - t_clr, 2);
    chk(t_wr > t_inh, "R2 inhibit before write", t_wr, t_inh + 1);
    chk(bad_wlen == 0, "R3 write length", bad_wlen, 0);
    chk(bad_wdat == 0, "R3 write data", bad_wdat, 0);
    chk(!done_sup, "R7 supplies nominal at done", int'(done_sup), 0);
    chk(done_prev == MODE_CLEAR, "R7 clear before done", int'(done_prev), int'(MODE_CLEAR));
    @(negedge clk);
    chk(!done, "R7 done one cycle", int'(done), 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check_idle("R1 in reset");
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check_idle("R1 after reset");

    // table walk
    for (int r = 0; r < NROWS; r++) run_row(r);

    // reset in the middle of a burn
    cur_base = 8'h11;
    for (int a = 0; a <= NB; a++) begin need_m[a] = 3; pulses[a] = 0; end
    t_start = -1; t_clr = -1; t_sup = -1; t_inh = -1; t_wr = -1;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    repeat (60) @(posedge clk);
    #1 rst_n = 1'b0;
    @(negedge clk);
    check_idle("R1 reset mid-run");
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check_idle("R1 idle after mid-run reset");
    run_row(1);

    finish_now();
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "global watchdog R7", 190000, 0);
    finish_now();
  end

endmodule